// File: doc/BRIEF.md
# PLL Retune Sequencer

This block changes the multiplier setting of a PLL without glitching the clock it feeds. On a start strobe it captures the new packed multiplier word. It then walks the PLL through a fixed sequence of register writes: power down and strip every pass-through path, load the new multiplier, load the pre/post divider word that selects divide-by-one, and power back up. After power-up it waits a settle interval, then polls the lock indication a bounded number of times. The output clock enable is opened only once lock is confirmed.

The block owns the five-bit control image of the PLL. It presents that image together with one-cycle write strobes for the control, multiplier and divider registers, so that the surrounding logic only has to apply each strobe to the matching register. One cycle-long done pulse closes each sequence. An error flag, valid only in that cycle, tells a locked finish from one that timed out.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, ctrl_o is 5'b00001 (powered down, everything else off), all write strobes are low, and done_o and err_o are low.
- R2: The first write after an accepted start is a control write with bit 0 (power-down) set and bits 1 (bypass), 2 (direct input), 3 (direct output) and 4 (clock enable) cleared, whatever the image held before.
- R3: The next two writes, in order, are a multiplier write carrying the word captured at start, then a divider write carrying 32'h00302062.
- R4: The fourth write is a control write that clears only bit 0 and leaves bits 4..1 as they were (all clear).
- R5: The synchronised lock input is sampled every SETTLE+1 cycles after the power-up control write, where SETTLE = CLK_HZ*SETTLE_NS/1e9 cycles. The first sample falls SETTLE+1 cycles after that write.
- R6: On the first sample that shows lock, a control write sets bit 4. In the same cycle done_o pulses with err_o low.
- R7: If none of MAX_TRIES samples shows lock, done_o pulses with err_o high MAX_TRIES*(SETTLE+1) cycles after the power-up write. No control write follows, so bit 4 stays clear.
- R8: A start strobe that arrives while a sequence is in progress is ignored: it produces no write and does not change the captured word.
- R9: done_o is high for exactly one cycle, and err_o is never high outside that cycle.
- R10: The lock input passes through a two-flop synchroniser. A lock level that rises during a settle window is honoured at the next sample that falls at least two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; ignored while busy |
| mult_word_i | input | CFG_W | New packed multiplier configuration word |
| lock_i | input | 1 | Asynchronous PLL lock indication |
| ctrl_o | output | 5 | Control image: [0] power-down, [1] bypass, [2] direct input, [3] direct output, [4] clock enable |
| ctrl_we_o | output | 1 | Control register write strobe |
| mult_o | output | CFG_W | Multiplier register write data |
| mult_we_o | output | 1 | Multiplier register write strobe |
| npdiv_o | output | 32 | Pre/post divider write data |
| npdiv_we_o | output | 1 | Divider register write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Lock failure, valid with done_o |

## Verification
The bench builds the block with CLK_HZ at 50 MHz, SETTLE_NS at 200 and MAX_TRIES at 4. That gives a ten-cycle settle window, so a run of all four failed polls finishes in 44 cycles after power-up. This makes the exhaustion path, the late-lock path on the third poll and back-to-back sequences cheap to reach, and the window stays longer than the synchroniser delay, so a lock raised mid-window lands on a predictable sample. Write order, write data and the spacing from power-up to done are compared against expectations that the driver computes from these parameters.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SETTLE_NS  = 10_000,
  parameter int MAX_TRIES  = 4,
  parameter int CFG_W      = 32,
  parameter logic [31:0] NPDIV_WORD = 32'h0030_2062
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] mult_word_i,
  input  logic             lock_i,
  output logic [4:0]       ctrl_o,
  output logic             ctrl_we_o,
  output logic [CFG_W-1:0] mult_o,
  output logic             mult_we_o,
  output logic [31:0]      npdiv_o,
  output logic             npdiv_we_o,
  output logic             done_o,
  output logic             err_o
);
  localparam longint RAW_CYC = (longint'(CLK_HZ) * longint'(SETTLE_NS)) / 64'd1_000_000_000;
  localparam int SETTLE_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int B_PD = 0, B_CEN = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_MULT, S_NPDIV, S_PWRUP, S_WAIT, S_SAMPLE
  } state_t;

  state_t          state;
  logic [4:0]      ctrl_q;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tries;
  logic            lock_meta, lock_s;

  assign ctrl_o  = ctrl_q;
  assign npdiv_o = NPDIV_WORD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ctrl_q     <= 5'b00001;
      ctrl_we_o  <= 1'b0;
      mult_o     <= '0;
      mult_we_o  <= 1'b0;
      npdiv_we_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      cnt        <= '0;
      tries      <= '0;
      lock_meta  <= 1'b0;
      lock_s     <= 1'b0;
    end else begin
      lock_meta  <= lock_i;
      lock_s     <= lock_meta;
      ctrl_we_o  <= 1'b0;
      mult_we_o  <= 1'b0;
      npdiv_we_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          mult_o    <= mult_word_i;
          ctrl_q    <= 5'b00001;
          ctrl_we_o <= 1'b1;
          state     <= S_MULT;
        end
        S_MULT: begin
          mult_we_o <= 1'b1;
          state     <= S_NPDIV;
        end
        S_NPDIV: begin
          npdiv_we_o <= 1'b1;
          state      <= S_PWRUP;
        end
        S_PWRUP: begin
          ctrl_q[B_PD] <= 1'b0;
          ctrl_we_o    <= 1'b1;
          cnt          <= CW'(SETTLE_CYC - 1);
          tries        <= '0;
          state        <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_SAMPLE;
          else           cnt   <= cnt - 1'b1;
        end
        S_SAMPLE: begin
          if (lock_s) begin
            ctrl_q[B_CEN] <= 1'b1;
            ctrl_we_o     <= 1'b1;
            done_o        <= 1'b1;
            state         <= S_IDLE;
          end else if (tries == TW'(MAX_TRIES - 1)) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            state  <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
            cnt   <= CW'(SETTLE_CYC - 1);
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module pll_retune_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ctrl_o,
  input logic       ctrl_we_o,
  input logic       mult_we_o,
  input logic       npdiv_we_o,
  input logic       done_o,
  input logic       err_o
);
  // R2
  pd_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we_o && ctrl_o[0]) |-> (ctrl_o[4:1] == 4'b0000));
  // R3
  mult_then_npdiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mult_we_o |=> npdiv_we_o);
  // R4
  npdiv_then_pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npdiv_we_o |=> (ctrl_we_o && !ctrl_o[0] && ctrl_o[4:1] == 4'b0000));
  // R6
  clken_with_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we_o && ctrl_o[4]) |-> (done_o && !err_o));
  // R7
  fail_keeps_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> !ctrl_o[4]);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  err_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

bind pll_retune_seq pll_retune_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_o(ctrl_o), .ctrl_we_o(ctrl_we_o),
  .mult_we_o(mult_we_o), .npdiv_we_o(npdiv_we_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/pll_retune_seq_tb.sv
module pll_retune_seq_tb;
  localparam int S = 10;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] mult_word_i = '0;
  logic        lock_i = 1'b0;
  logic [4:0]  ctrl_o;
  logic        ctrl_we_o, mult_we_o, npdiv_we_o, done_o, err_o;
  logic [31:0] mult_o, npdiv_o;

  always #10 clk = ~clk;

  pll_retune_seq #(.CLK_HZ(50_000_000), .SETTLE_NS(200), .MAX_TRIES(T), .CFG_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_word_i(mult_word_i),
    .lock_i(lock_i), .ctrl_o(ctrl_o), .ctrl_we_o(ctrl_we_o), .mult_o(mult_o),
    .mult_we_o(mult_we_o), .npdiv_o(npdiv_o), .npdiv_we_o(npdiv_we_o),
    .done_o(done_o), .err_o(err_o)
  );

  int nchk = 0, nbad = 0, cyc = 0;
  int pu_cyc = 0, done_cyc = 0;
  bit pu_seen = 0, done_seen = 0, done_prev = 0;
  logic [35:0] expq[$];   // {kind[3:0], data[31:0]}: 1 ctrl, 2 mult, 3 npdiv, 4 done(err)

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input logic [3:0] kind, input logic [31:0] data);
    logic [35:0] e;
    if (expq.size() == 0) begin
      chk(0, "R8 unexpected write", {28'd0, kind}, 32'd0);
    end else begin
      e = expq.pop_front();
      chk(e == {kind, data}, "R2/R3/R4/R6/R7 sequence", {kind, data[27:0]}, {e[35:32], e[27:0]});
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (ctrl_we_o) begin
      pop_cmp(4'd1, {27'd0, ctrl_o});
      if (!ctrl_o[0] && !ctrl_o[4]) begin pu_seen = 1; pu_cyc = cyc; end
    end
    if (mult_we_o)  pop_cmp(4'd2, mult_o);
    if (npdiv_we_o) pop_cmp(4'd3, npdiv_o);
    if (done_o) begin
      pop_cmp(4'd4, {31'd0, err_o});
      done_seen = 1; done_cyc = cyc;
    end
    if (done_prev) chk(!done_o, "R9 done one cycle", {31'd0, done_o}, 32'd0);
    if (!done_o) chk(!err_o, "R9 err outside done", {31'd0, err_o}, 32'd0);
    done_prev = done_o;
  end

  // driver: mode 0 lock high, 1 never, 2 lock rises mid third window with stray start
  task automatic run(input logic [31:0] word, input int mode, input int exp_lat);
    expq.push_back({4'd1, 32'h01});
    expq.push_back({4'd2, word});
    expq.push_back({4'd3, 32'h0030_2062});
    expq.push_back({4'd1, 32'h00});
    if (mode == 1) expq.push_back({4'd4, 32'd1});
    else begin
      expq.push_back({4'd1, 32'h10});
      expq.push_back({4'd4, 32'd0});
    end
    lock_i = (mode == 0);
    pu_seen = 0; done_seen = 0;
    @(negedge clk); mult_word_i = word; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; mult_word_i = ~word;
    while (!done_seen) begin
      @(negedge clk);
      if (mode == 2 && pu_seen && cyc - pu_cyc == 5) begin
        mult_word_i = 32'hDEAD_BEEF; start_i = 1'b1;   // R8 stray start
      end else start_i = 1'b0;
      if (mode == 2 && pu_seen && cyc - pu_cyc == 2 * (S + 1) + 5) lock_i = 1'b1;  // R10
    end
    start_i = 1'b0;
    chk(done_cyc - pu_cyc == exp_lat, "R5/R7 power-up to done spacing", done_cyc - pu_cyc, exp_lat);
    @(negedge clk);
    chk(ctrl_o[4] == (mode != 1), "R6/R7 clock enable after finish", {27'd0, ctrl_o}, {31'd0, mode != 1});
    chk(expq.size() == 0, "R3 all writes seen", expq.size(), 0);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0 && !done_o, "R8 no extra activity", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(ctrl_o == 5'b00001, "R1 reset ctrl", {27'd0, ctrl_o}, 32'h1);
    chk(!ctrl_we_o && !mult_we_o && !npdiv_we_o, "R1 reset strobes", {29'd0, ctrl_we_o, mult_we_o, npdiv_we_o}, 0);
    chk(!done_o && !err_o, "R1 reset flags", {30'd0, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h00A5_1234, 0, S + 1);         // R5 R6
    run(32'h0123_4567, 1, T * (S + 1));   // R2 from enabled image, R7
    run(32'h7FFF_0001, 2, 3 * (S + 1));   // R5 R8 R10
    run(32'h0000_0003, 0, S + 1);         // back-to-back R2
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule